// File: doc/BRIEF.md
# Implicit-Operand Queue Execution Core

This block is the execution stage of a processor that keeps all working values in a circular operand queue instead of a register file. Each decoded 16-bit instruction carries an 8-bit opcode in its upper byte and an 8-bit argument in its lower byte. The instruction names no destination. Every result goes to the tail of the queue. The first source of a two-input operation is the entry at the head. The other source is the entry a given distance from the head. Reading at a distance removes nothing, so a value can feed several later operations. A copy operation duplicates any reachable entry to the tail. A prefix instruction supplies upper bits for the argument of the instruction that follows it, which allows wide constants and long distances.

One instruction is accepted per cycle while `in_valid` is high. The result, the fault pulses and the new occupancy all appear one cycle later. The entry at the head is always visible on `head_data`, so a caller can watch the queue through the normal outputs.

Prefix handling is a two-state machine. In state `PF_IDLE` no prefix is pending and the argument is the 8-bit field, zero-extended. A prefix instruction moves it to `PF_HELD` (transition *capture*), and the field is stored in the extension register. A further prefix in `PF_HELD` stays in that state (transition *chain*) and shifts the stored bits up by eight before it appends the new field. Any other accepted instruction in `PF_HELD` consumes the extension and returns the machine to `PF_IDLE` (transition *consume*). Faulted and undefined instructions also consume it.

Top module: `oq_exec`

## Requirements
- R1: After reset the occupancy is 0 and `res_valid`, `ovf_flag` and `unf_flag` are low.
- R2: Opcode 0x01 (load) enqueues its argument, zero-extended to 32 bits, at the tail and raises occupancy by one. The first value loaded into an empty queue appears on `head_data`.
- R3: Opcodes 0x02 (add), 0x03 (subtract, head minus far operand) and 0x04 (multiply, low 32 bits) read the head entry and the entry N places past the head, where N is the argument. They enqueue the result and advance the head by one, so occupancy is unchanged. The entry read at distance N stays in the queue.
- R4: Opcode 0x05 enqueues the two's-complement negation of the entry N places past the head. The head advances by one only when N is 0.
- R5: Opcode 0x06 enqueues a copy of the entry N places past the head. The head advances by one only when N is 0.
- R6: Opcode 0x07 (prefix) produces no result and leaves the queue untouched. The next instruction's argument is the stored bits followed by its own 8-bit field. Consecutive prefixes concatenate, with the earlier one in the higher bits. The stored bits apply to exactly one following instruction.
- R7: An instruction that would make occupancy exceed 16 is not executed: `ovf_flag` pulses for one cycle and the queue is unchanged. This covers a load, or a negate or copy with N ≠ 0, on a full queue. A two-input operation on a full queue still executes.
- R8: An operation that reads at distance N with N ≥ occupancy is not executed: `unf_flag` pulses for one cycle and the queue is unchanged. This condition takes precedence over overflow.
- R9: Head and tail wrap from entry 15 to entry 0, so long runs of operations keep giving correct results.
- R10: Any opcode other than 0x01 to 0x07 leaves the queue and the outputs unchanged and produces no result, but it does consume a pending prefix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_instr | input | 16 | Opcode in bits 15:8, argument in bits 7:0 |
| res_valid | output | 1 | A result was enqueued by the previous instruction |
| res_data | output | 32 | Value enqueued by the previous instruction |
| ovf_flag | output | 1 | Previous instruction rejected for overflow |
| unf_flag | output | 1 | Previous instruction rejected for underflow |
| occupancy | output | 5 | Number of live entries (0 to 16) |
| head_data | output | 32 | Entry currently at the head |

## Verification
A wrong head or tail pointer shows on the very next `res_data`: the next two-input operation combines the wrong entries, and `head_data` changes within the same cycle that the pointer moves. A stale or lost prefix turns up as a wrong constant on the next load. A wrong occupancy count appears directly on `occupancy`, and it also moves the point where overflow or underflow fires by one instruction. The bench therefore keeps its own model of the queue and compares every output after every instruction. Pointer wrap is exercised by a long dependent chain, so a wrap fault corrupts every value that follows it.

// File: rtl/oq_pkg.sv
package oq_pkg;

    typedef enum logic [7:0] {
        OP_LDI = 8'h01,
        OP_ADD = 8'h02,
        OP_SUB = 8'h03,
        OP_MUL = 8'h04,
        OP_NEG = 8'h05,
        OP_DUP = 8'h06,
        OP_EXT = 8'h07
    } opcode_e;

    typedef enum logic [2:0] {
        K_NONE,
        K_LOAD,
        K_BIN,
        K_UN,
        K_COPY,
        K_PREFIX
    } kind_e;

    typedef enum logic [2:0] {
        AL_ADD,
        AL_SUB,
        AL_MUL,
        AL_NEG,
        AL_PASS
    } alu_op_e;

    typedef enum logic {
        PF_IDLE,
        PF_HELD
    } pf_state_e;

endpackage

// File: rtl/oq_decode.sv
module oq_decode
    import oq_pkg::*;
(
    input  logic [7:0] opcode,
    output kind_e      kind,
    output alu_op_e    aop
);
    always_comb begin
        kind = K_NONE;
        aop  = AL_PASS;
        unique case (opcode)
            OP_LDI: begin kind = K_LOAD;   aop = AL_PASS; end
            OP_ADD: begin kind = K_BIN;    aop = AL_ADD;  end
            OP_SUB: begin kind = K_BIN;    aop = AL_SUB;  end
            OP_MUL: begin kind = K_BIN;    aop = AL_MUL;  end
            OP_NEG: begin kind = K_UN;     aop = AL_NEG;  end
            OP_DUP: begin kind = K_COPY;   aop = AL_PASS; end
            OP_EXT: begin kind = K_PREFIX; aop = AL_PASS; end
            default: begin kind = K_NONE;  aop = AL_PASS; end
        endcase
    end
endmodule

// File: rtl/oq_prefix.sv
module oq_prefix
    import oq_pkg::*;
#(
    parameter int DW  = 32,
    parameter int FW  = 8,
    localparam int XW = DW - FW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          is_prefix,
    input  logic [FW-1:0] field,
    output logic [DW-1:0] arg
);
    pf_state_e state, state_nx;
    logic [XW-1:0] ext_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            PF_IDLE: if (take && is_prefix)  state_nx = PF_HELD;  // capture
            PF_HELD: if (take && !is_prefix) state_nx = PF_IDLE;  // consume
            default: state_nx = PF_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= PF_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q <= '0;
        end else if (take && is_prefix) begin
            if (state == PF_HELD) ext_q <= {ext_q[XW-FW-1:0], field};  // chain
            else                  ext_q <= {{(XW-FW){1'b0}}, field};
        end
    end

    always_comb begin
        unique case (state)
            PF_HELD: arg = {ext_q, field};
            default: arg = {{XW{1'b0}}, field};
        endcase
    end

    a_r6_prefix_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !is_prefix) |=> (state == PF_IDLE));
endmodule

// File: rtl/oq_alu.sv
module oq_alu
    import oq_pkg::*;
#(
    parameter int DW = 32
) (
    input  alu_op_e       aop,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y
);
    always_comb begin
        unique case (aop)
            AL_ADD:  y = a + b;
            AL_SUB:  y = a - b;
            AL_MUL:  y = a * b;
            AL_NEG:  y = '0 - b;
            default: y = b;
        endcase
    end
endmodule

// File: rtl/oq_ring.sv
module oq_ring #(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    input  logic [PW-1:0] rd_off,
    output logic [DW-1:0] head_q,
    output logic [DW-1:0] far_q,
    output logic [CW-1:0] count
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] head, tail;
    logic [PW:0]   far_sum;
    logic [PW-1:0] far_addr;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        far_sum  = {1'b0, head} + {1'b0, rd_off};
        far_addr = (far_sum >= (PW+1)'(DEPTH)) ? PW'(far_sum - (PW+1)'(DEPTH))
                                               : far_sum[PW-1:0];
    end

    assign head_q = mem[head];
    assign far_q  = mem[far_addr];

    always_ff @(posedge clk) begin
        if (push) mem[tail] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push) tail <= step(tail);
            if (pop)  head <= step(head);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    a_r9_ptr_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (count != CW'(DEPTH)) |-> (PW'(tail - head) == count[PW-1:0]));
endmodule

// File: rtl/oq_exec.sv
module oq_exec
    import oq_pkg::*;
#(
    parameter int DW    = 32,
    parameter int IW    = 16,
    parameter int DEPTH = 16,
    localparam int FW   = IW / 2,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [IW-1:0] in_instr,
    output logic          res_valid,
    output logic [DW-1:0] res_data,
    output logic          ovf_flag,
    output logic          unf_flag,
    output logic [CW-1:0] occupancy,
    output logic [DW-1:0] head_data
);
    kind_e         kind;
    alu_op_e       aop;
    logic [DW-1:0] arg, head_q, far_q, alu_b, alu_y;
    logic          reads_far, wants_pop, wants_push, unf_c, ovf_c, go;

    oq_decode u_dec (
        .opcode (in_instr[IW-1:FW]),
        .kind   (kind),
        .aop    (aop)
    );

    oq_prefix #(.DW(DW), .FW(FW)) u_pfx (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (in_valid),
        .is_prefix (kind == K_PREFIX),
        .field     (in_instr[FW-1:0]),
        .arg       (arg)
    );

    always_comb begin
        reads_far  = (kind == K_BIN) || (kind == K_UN) || (kind == K_COPY);
        wants_pop  = (kind == K_BIN) ||
                     (((kind == K_UN) || (kind == K_COPY)) && (arg == '0));
        wants_push = reads_far || (kind == K_LOAD);
        unf_c      = in_valid && reads_far && (arg >= DW'(occupancy));
        ovf_c      = in_valid && !unf_c && wants_push && !wants_pop &&
                     (occupancy == CW'(DEPTH));
        go         = in_valid && wants_push && !unf_c && !ovf_c;
        alu_b      = (kind == K_LOAD) ? arg : far_q;
    end

    oq_alu #(.DW(DW)) u_alu (
        .aop (aop),
        .a   (head_q),
        .b   (alu_b),
        .y   (alu_y)
    );

    oq_ring #(.DW(DW), .DEPTH(DEPTH)) u_ring (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (go),
        .pop    (go && wants_pop),
        .wdata  (alu_y),
        .rd_off (arg[PW-1:0]),
        .head_q (head_q),
        .far_q  (far_q),
        .count  (occupancy)
    );

    assign head_data = head_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
            ovf_flag  <= 1'b0;
            unf_flag  <= 1'b0;
        end else begin
            res_valid <= go;
            res_data  <= go ? alu_y : res_data;
            ovf_flag  <= ovf_c;
            unf_flag  <= unf_c;
        end
    end

    a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_flag && unf_flag));
    a_r7_ovf_only_full: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |-> (occupancy == CW'(DEPTH)));
    a_r8_unf_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
        unf_flag |-> (occupancy == $past(occupancy)));
    a_r2_load_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_instr[IW-1:FW] == OP_LDI && occupancy < CW'(DEPTH))
        |=> (occupancy == $past(occupancy) + 1'b1));
    a_r6_prefix_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_instr[IW-1:FW] == OP_EXT) |=> (!res_valid && $stable(occupancy)));
endmodule

// File: tb/sim_oq_exec.sv
module sim_oq_exec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_instr = '0;
    logic        res_valid, ovf_flag, unf_flag;
    logic [31:0] res_data, head_data;
    logic [4:0]  occupancy;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [31:0] mq [16];
    int          mh, mc;
    bit          mext_p;
    logic [23:0] mext;

    always #4 clk = ~clk;

    oq_exec u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
        .res_valid(res_valid), .res_data(res_data), .ovf_flag(ovf_flag),
        .unf_flag(unf_flag), .occupancy(occupancy), .head_data(head_data)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mh = 0; mc = 0; mext_p = 0; mext = '0;
        @(negedge clk);
    endtask

    task automatic push_m(input logic [31:0] v, inout bit rv, inout logic [31:0] rd);
        mq[(mh + mc) % 16] = v;
        mc++;
        rv = 1; rd = v;
    endtask

    task automatic issue(input logic [7:0] op, input logic [7:0] a, input string tag);
        logic [31:0] imm, x, y;
        bit rv, eo, eu;
        logic [31:0] rd;
        rv = 0; eo = 0; eu = 0; rd = '0;
        imm = mext_p ? {mext, a} : {24'b0, a};
        if (op == 8'h07) begin
            mext = mext_p ? {mext[15:0], a} : {16'b0, a};
            mext_p = 1;
        end else begin
            mext_p = 0;
            case (op)
                8'h01: if (mc == 16) eo = 1; else push_m(imm, rv, rd);
                8'h02, 8'h03, 8'h04: begin
                    if (imm >= 32'(mc)) eu = 1;
                    else begin
                        x = mq[mh];
                        y = mq[(mh + int'(imm)) % 16];
                        mh = (mh + 1) % 16; mc--;
                        push_m(op == 8'h02 ? x + y : op == 8'h03 ? x - y : x * y, rv, rd);
                    end
                end
                8'h05, 8'h06: begin
                    if (imm >= 32'(mc)) eu = 1;
                    else if (imm != 0 && mc == 16) eo = 1;
                    else begin
                        y = mq[(mh + int'(imm)) % 16];
                        if (imm == 0) begin mh = (mh + 1) % 16; mc--; end
                        push_m(op == 8'h05 ? 32'd0 - y : y, rv, rd);
                    end
                end
                default: ;
            endcase
        end
        in_valid = 1'b1; in_instr = {op, a};
        @(negedge clk);
        in_valid = 1'b0;
        check(res_valid == rv, tag, "res_valid", 32'(res_valid), 32'(rv));
        if (rv) check(res_data == rd, tag, "res_data", res_data, rd);
        check(ovf_flag == eo, tag, "ovf_flag", 32'(ovf_flag), 32'(eo));
        check(unf_flag == eu, tag, "unf_flag", 32'(unf_flag), 32'(eu));
        check(occupancy == 5'(mc), tag, "occupancy", 32'(occupancy), 32'(mc));
        if (mc > 0) check(head_data == mq[mh], tag, "head_data", head_data, mq[mh]);
    endtask

    task automatic t_reset();  // R1
        do_reset();
        check(occupancy == 0, "R1", "occupancy", 32'(occupancy), 0);
        check(!res_valid, "R1", "res_valid", 32'(res_valid), 0);
        check(!ovf_flag && !unf_flag, "R1", "flags", {30'b0, ovf_flag, unf_flag}, 0);
    endtask

    task automatic t_load();  // R2
        do_reset();
        issue(8'h01, 8'h05, "R2");
        issue(8'h01, 8'hFF, "R2");
        issue(8'h01, 8'h80, "R2");
    endtask

    task automatic t_binary();  // R3
        do_reset();
        issue(8'h01, 8'd7, "R3");
        issue(8'h01, 8'd3, "R3");
        issue(8'h01, 8'd10, "R3");
        issue(8'h03, 8'd1, "R3");
        issue(8'h02, 8'd2, "R3");
        issue(8'h04, 8'd0, "R3");
        issue(8'h03, 8'd2, "R3");
        issue(8'h04, 8'd1, "R3");
    endtask

    task automatic t_unary();  // R4
        do_reset();
        issue(8'h01, 8'd9, "R4");
        issue(8'h01, 8'd4, "R4");
        issue(8'h05, 8'd1, "R4");
        issue(8'h05, 8'd0, "R4");
        issue(8'h05, 8'd2, "R4");
    endtask

    task automatic t_dup();  // R5
        do_reset();
        issue(8'h01, 8'd11, "R5");
        issue(8'h01, 8'd22, "R5");
        issue(8'h06, 8'd1, "R5");
        issue(8'h06, 8'd0, "R5");
        issue(8'h02, 8'd1, "R5");
    endtask

    task automatic t_prefix();  // R6
        do_reset();
        issue(8'h07, 8'h12, "R6");
        issue(8'h01, 8'h34, "R6");
        issue(8'h07, 8'h01, "R6");
        issue(8'h07, 8'h02, "R6");
        issue(8'h01, 8'h03, "R6");
        issue(8'h01, 8'h05, "R6");
        issue(8'h07, 8'hAB, "R6");
        issue(8'h07, 8'hCD, "R6");
        issue(8'h07, 8'hEF, "R6");
        issue(8'h01, 8'h01, "R6");
        issue(8'h07, 8'h00, "R6");
        issue(8'h06, 8'h02, "R6");
    endtask

    task automatic t_overflow();  // R7
        do_reset();
        for (int i = 0; i < 16; i++) issue(8'h01, 8'(i + 1), "R7");
        issue(8'h01, 8'h63, "R7");
        issue(8'h06, 8'd3, "R7");
        issue(8'h05, 8'd1, "R7");
        issue(8'h02, 8'd1, "R7");
        issue(8'h06, 8'd0, "R7");
        issue(8'h05, 8'd0, "R7");
    endtask

    task automatic t_underflow();  // R8
        do_reset();
        issue(8'h02, 8'd0, "R8");
        issue(8'h05, 8'd0, "R8");
        issue(8'h01, 8'd1, "R8");
        issue(8'h02, 8'd1, "R8");
        issue(8'h06, 8'd5, "R8");
        issue(8'h07, 8'h01, "R8");
        issue(8'h02, 8'h00, "R8");
        for (int i = 0; i < 15; i++) issue(8'h01, 8'(i), "R8");
        issue(8'h06, 8'd16, "R8");
    endtask

    task automatic t_wrap();  // R9
        do_reset();
        issue(8'h01, 8'd1, "R9");
        issue(8'h01, 8'd2, "R9");
        issue(8'h01, 8'd3, "R9");
        for (int i = 0; i < 60; i++) issue(8'h02, 8'd2, "R9");
        for (int i = 0; i < 13; i++) issue(8'h01, 8'(i * 7), "R9");
        for (int i = 0; i < 40; i++) issue(i % 2 ? 8'h04 : 8'h03, 8'(i % 16), "R9");
    endtask

    task automatic t_undef();  // R10
        do_reset();
        issue(8'h01, 8'd9, "R10");
        issue(8'h55, 8'd0, "R10");
        issue(8'h00, 8'd3, "R10");
        issue(8'hFF, 8'hFF, "R10");
        issue(8'h07, 8'h77, "R10");
        issue(8'h08, 8'd0, "R10");
        issue(8'h01, 8'h01, "R10");
    endtask

    initial begin
        t_reset();
        t_load();
        t_binary();
        t_unary();
        t_dup();
        t_prefix();
        t_overflow();
        t_underflow();
        t_wrap();
        t_undef();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule